// File: doc/BRIEF.md
# Double-Buffered 128-to-32 Bit Burst Bridge

This block connects a 128-bit internal memory port to a 32-bit external data port and carries whole bursts across the width change. A burst is opened by a one-cycle start pulse that gives the direction, a 27-bit byte address and a length of one to sixteen 128-bit words. During an outbound (read) burst, each internal word is fetched and then presented on the external side as four 32-bit beats. During an inbound (write) burst, four external beats are gathered into one internal word, and that word is written to the internal side once it is complete.

Each direction has its own pair of 128-bit buffers, used in ping-pong fashion. While one buffer is exchanged with the external side, the other is exchanged with the internal side. A burst whose two sides are both always ready therefore runs without idle beats. Address decode, arbitration and memory timing are handled outside the block. The internal port is a plain request/ready pair. The external data port uses valid/ready handshakes in both directions.

Top module: `burst_width_bridge`

## Requirements
- R1: After reset, xferActive, intReq, extRvalid and extWready are all low.
- R2: When the bridge is idle, a start pulse is accepted. The burst length is extLen+1 words (extLen 0 gives 1 word, 15 gives 16 words), and extWrite=1 selects an inbound burst. xferActive is high from the cycle after the pulse until the burst completes.
- R3: Internal access number i of a burst (counting from 0) uses intAddr[26:4] = extAddr[26:4] + i, modulo 2^23. Bits [3:0] repeat extAddr[3:0]. intWe is 1 for inbound bursts and 0 for outbound bursts.
- R4: An outbound word is sent as four beats: bits [31:0] first, then [63:32], then [95:64], then [127:96]. Words are sent in address order.
- R5: Inbound beats are packed first beat into bits [31:0], up to the fourth beat into [127:96]. A word is requested on the internal side only after all four of its beats have been accepted.
- R6: intReq stays high with intAddr and intWe unchanged until intReady. extRvalid stays high with extRdata unchanged until extRready. Stalls on either side lose and repeat no data.
- R7: If the opposite side is always ready (intReady held high) and the external side never stalls, a burst of N words moves 4N beats on consecutive cycles with no idle beat.
- R8: On an outbound burst, in the first cycle that a word is presented externally, the fetch of the next word is already complete or is being requested.
- R9: A start pulse that arrives while a burst is active is ignored. The active burst keeps its direction, length, address and data.
- R10: A burst ends after exactly N internal accesses and 4N beats. xferActive then drops, and intReq, extRvalid and extWready stay low while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| extStart | input | 1 | Burst start pulse, taken only while idle |
| extWrite | input | 1 | 1: inbound (external to internal) burst |
| extAddr | input | 27 | Byte address of the first word |
| extLen | input | 4 | Burst length minus one, in 128-bit words |
| xferActive | output | 1 | High while a burst is in progress |
| intReq | output | 1 | Internal access request |
| intWe | output | 1 | Internal access is a write |
| intAddr | output | 27 | Internal access byte address |
| intWdata | output | 128 | Internal write word |
| intRdata | input | 128 | Internal read word, taken when intReq and intReady are high |
| intReady | input | 1 | Internal access completes this cycle |
| extRdata | output | 32 | Outbound beat |
| extRvalid | output | 1 | Outbound beat valid |
| extRready | input | 1 | External side accepts outbound beat |
| extWdata | input | 32 | Inbound beat |
| extWvalid | input | 1 | Inbound beat valid |
| extWready | output | 1 | Bridge accepts inbound beat |

## Verification
A buffer-select or full-flag error appears at the ports within one word time, that is, four beats. It shows as a repeated or stale 128-bit word on the external beats, or as a write word carrying another word's beats. A beat-counter slip shuffles 32-bit lanes inside the next word. A word-count error shows as a burst that ends early or late against the 4N beat total. A missed prefetch shows as an idle beat between words under full readiness. The bench sweeps every length in both directions, with and without pseudo-random stalls, and also covers an address that wraps and a start pulse sent mid-burst.

// File: rtl/bwb_pkg.sv
package bwb_pkg;
  // strobes handed from control to datapath each cycle
  typedef struct packed {
    logic rdLoad;    // capture intRdata into outbound buffer fillSel
    logic wrBeatEn;  // capture extWdata lane into inbound buffer fillSel
    logic fillSel;   // buffer on the filling side
    logic drainSel;  // buffer on the draining side
  } bwb_strobe_t;
endpackage

// File: rtl/bwb_ctrl.sv
module bwb_ctrl
  import bwb_pkg::*;
#(
  parameter int ADDR_W = 27,
  parameter int LEN_W  = 4,
  parameter int BEATS  = 4,
  parameter int OFS_W  = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     extStart,
  input  logic                     extWrite,
  input  logic [ADDR_W-1:0]        extAddr,
  input  logic [LEN_W-1:0]         extLen,
  input  logic                     extRready,
  input  logic                     extWvalid,
  input  logic                     intReady,
  output logic                     xferActive,
  output logic                     intReq,
  output logic                     intWe,
  output logic [ADDR_W-1:0]        intAddr,
  output logic                     extRvalid,
  output logic                     extWready,
  output bwb_strobe_t              strb,
  output logic [$clog2(BEATS)-1:0] beatIdx
);
  localparam int BEAT_W  = $clog2(BEATS);
  localparam int WADDR_W = ADDR_W - OFS_W;
  localparam int CNT_W   = LEN_W + 1;

  logic               active;
  logic               dirWr;
  logic [LEN_W-1:0]   lastIdx;
  logic [WADDR_W-1:0] baseWord;
  logic [OFS_W-1:0]   baseOfs;
  // fillCnt: words that entered buffers; drainCnt: words that left them
  logic [CNT_W-1:0]   fillCnt, drainCnt;
  logic [1:0]         full, fullNext;
  logic               fillSel, drainSel;
  logic [BEAT_W-1:0]  beat;

  logic [CNT_W-1:0]   lastCnt, reqIdx;
  logic fillOpen, drainOpen, lastBeat, rdReq, wrReq;
  logic beatFire, fillFire, drainFire;

  always_comb begin
    lastCnt   = {1'b0, lastIdx};
    fillOpen  = active && (fillCnt <= lastCnt) && !full[fillSel];
    drainOpen = active && full[drainSel];
    lastBeat  = (beat == BEAT_W'(BEATS - 1));
    rdReq     = !dirWr && fillOpen;
    wrReq     = dirWr && drainOpen;
    extRvalid = !dirWr && drainOpen;
    extWready = dirWr && fillOpen;
    beatFire  = dirWr ? (extWready && extWvalid) : (extRvalid && extRready);
    fillFire  = dirWr ? (beatFire && lastBeat) : (rdReq && intReady);
    drainFire = dirWr ? (wrReq && intReady) : (beatFire && lastBeat);
    reqIdx    = dirWr ? drainCnt : fillCnt;
    intReq    = rdReq || wrReq;
    intWe     = wrReq;
    intAddr   = {baseWord + WADDR_W'(reqIdx), baseOfs};
    xferActive = active;

    fullNext = full;
    if (fillFire)  fullNext[fillSel]  = 1'b1;
    if (drainFire) fullNext[drainSel] = 1'b0;

    strb.rdLoad   = !dirWr && fillFire;
    strb.wrBeatEn = dirWr && beatFire;
    strb.fillSel  = fillSel;
    strb.drainSel = drainSel;
    beatIdx       = beat;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      dirWr    <= 1'b0;
      lastIdx  <= '0;
      baseWord <= '0;
      baseOfs  <= '0;
      fillCnt  <= '0;
      drainCnt <= '0;
      full     <= '0;
      fillSel  <= 1'b0;
      drainSel <= 1'b0;
      beat     <= '0;
    end else if (!active) begin
      if (extStart) begin
        active   <= 1'b1;
        dirWr    <= extWrite;
        lastIdx  <= extLen;
        baseWord <= extAddr[ADDR_W-1:OFS_W];
        baseOfs  <= extAddr[OFS_W-1:0];
        fillCnt  <= '0;
        drainCnt <= '0;
        full     <= '0;
        fillSel  <= 1'b0;
        drainSel <= 1'b0;
        beat     <= '0;
      end
    end else begin
      if (beatFire) beat <= beat + BEAT_W'(1);
      if (fillFire) begin
        fillSel <= ~fillSel;
        fillCnt <= fillCnt + CNT_W'(1);
      end
      if (drainFire) begin
        drainSel <= ~drainSel;
        drainCnt <= drainCnt + CNT_W'(1);
        if (drainCnt == lastCnt) active <= 1'b0;
      end
      full <= fullNext;
    end
  end
endmodule

// File: rtl/bwb_datapath.sv
module bwb_datapath
  import bwb_pkg::*;
#(
  parameter int INT_W = 128,
  parameter int EXT_W = 32
) (
  input  logic                             clk,
  input  bwb_strobe_t                      strb,
  input  logic [$clog2(INT_W/EXT_W)-1:0]   beatIdx,
  input  logic [INT_W-1:0]                 intRdata,
  input  logic [EXT_W-1:0]                 extWdata,
  output logic [EXT_W-1:0]                 extRdata,
  output logic [INT_W-1:0]                 intWdata
);
  localparam int NBUF = 2;

  logic [INT_W-1:0] outBuf [NBUF];
  logic [INT_W-1:0] inBuf  [NBUF];

  for (genvar g = 0; g < NBUF; g++) begin : g_buf
    logic [INT_W-1:0] outReg;
    logic [INT_W-1:0] inReg;
    logic             hit;
    assign hit = (strb.fillSel == 1'(g));
    always_ff @(posedge clk) begin
      if (strb.rdLoad && hit) outReg <= intRdata;
      if (strb.wrBeatEn && hit) inReg[int'(beatIdx)*EXT_W +: EXT_W] <= extWdata;
    end
    assign outBuf[g] = outReg;
    assign inBuf[g]  = inReg;
  end

  assign extRdata = outBuf[strb.drainSel][int'(beatIdx)*EXT_W +: EXT_W];
  assign intWdata = inBuf[strb.drainSel];
endmodule

// File: rtl/burst_width_bridge.sv
module burst_width_bridge
  import bwb_pkg::*;
#(
  parameter int INT_W  = 128,
  parameter int EXT_W  = 32,
  parameter int ADDR_W = 27,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extStart,
  input  logic              extWrite,
  input  logic [ADDR_W-1:0] extAddr,
  input  logic [LEN_W-1:0]  extLen,
  output logic              xferActive,
  output logic              intReq,
  output logic              intWe,
  output logic [ADDR_W-1:0] intAddr,
  output logic [INT_W-1:0]  intWdata,
  input  logic [INT_W-1:0]  intRdata,
  input  logic              intReady,
  output logic [EXT_W-1:0]  extRdata,
  output logic              extRvalid,
  input  logic              extRready,
  input  logic [EXT_W-1:0]  extWdata,
  input  logic              extWvalid,
  output logic              extWready
);
  localparam int BEATS  = INT_W / EXT_W;
  localparam int BEAT_W = $clog2(BEATS);
  localparam int OFS_W  = $clog2(INT_W / 8);

  bwb_strobe_t       strb;
  logic [BEAT_W-1:0] beatIdx;

  bwb_ctrl #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BEATS(BEATS), .OFS_W(OFS_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .extStart(extStart), .extWrite(extWrite), .extAddr(extAddr), .extLen(extLen),
    .extRready(extRready), .extWvalid(extWvalid), .intReady(intReady),
    .xferActive(xferActive), .intReq(intReq), .intWe(intWe), .intAddr(intAddr),
    .extRvalid(extRvalid), .extWready(extWready),
    .strb(strb), .beatIdx(beatIdx)
  );

  bwb_datapath #(
    .INT_W(INT_W), .EXT_W(EXT_W)
  ) u_dp (
    .clk(clk), .strb(strb), .beatIdx(beatIdx),
    .intRdata(intRdata), .extWdata(extWdata),
    .extRdata(extRdata), .intWdata(intWdata)
  );
endmodule

// File: rtl/bwb_checker.sv
module bwb_checker #(
  parameter int INT_W  = 128,
  parameter int EXT_W  = 32,
  parameter int ADDR_W = 27,
  parameter int LEN_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              xferActive,
  input logic              intReq,
  input logic              intWe,
  input logic              intReady,
  input logic [ADDR_W-1:0] intAddr,
  input logic              extRvalid,
  input logic              extRready,
  input logic [EXT_W-1:0]  extRdata,
  input logic              extWvalid,
  input logic              extWready
);
  localparam int BEATS = INT_W / EXT_W;
  localparam int CW    = LEN_W + $clog2(BEATS) + 2;

  logic [CW-1:0] beatCnt, cmtCnt;

  always_ff @(posedge clk) begin
    if (!rstN || !xferActive) begin
      beatCnt <= '0;
      cmtCnt  <= '0;
    end else begin
      if (extWvalid && extWready) beatCnt <= beatCnt + CW'(1);
      if (intReq && intWe && intReady) cmtCnt <= cmtCnt + CW'(1);
    end
  end

  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (intReq && !intReady) |=> (intReq && $stable(intAddr) && $stable(intWe)));

  p_rdata_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (extRvalid && !extRready) |=> (extRvalid && $stable(extRdata)));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !xferActive |-> (!intReq && !extRvalid && !extWready));

  p_dir_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    extRvalid |-> (!extWready && !(intReq && intWe)));

  p_commit_after_beats_r5: assert property (@(posedge clk) disable iff (!rstN)
    (intReq && intWe && intReady) |-> (int'(beatCnt) >= (int'(cmtCnt) + 1) * BEATS));
endmodule

bind burst_width_bridge bwb_checker #(
  .INT_W(INT_W), .EXT_W(EXT_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)
) u_chk (
  .clk(clk), .rstN(rstN), .xferActive(xferActive),
  .intReq(intReq), .intWe(intWe), .intReady(intReady), .intAddr(intAddr),
  .extRvalid(extRvalid), .extRready(extRready), .extRdata(extRdata),
  .extWvalid(extWvalid), .extWready(extWready)
);

// File: tb/burst_width_bridge_tb.sv
module burst_width_bridge_tb;
  logic         clk = 1'b0;
  logic         rstN;
  logic         extStart, extWrite;
  logic [26:0]  extAddr;
  logic [3:0]   extLen;
  logic         xferActive, intReq, intWe;
  logic [26:0]  intAddr;
  logic [127:0] intWdata, intRdata;
  logic         intReady;
  logic [31:0]  extRdata;
  logic         extRvalid, extRready;
  logic [31:0]  extWdata;
  logic         extWvalid, extWready;

  int vectors = 0;
  int miscompares = 0;
  int burstId = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;  // 250 MHz

  burst_width_bridge u_dut (
    .clk(clk), .rstN(rstN), .extStart(extStart), .extWrite(extWrite),
    .extAddr(extAddr), .extLen(extLen), .xferActive(xferActive),
    .intReq(intReq), .intWe(intWe), .intAddr(intAddr), .intWdata(intWdata),
    .intRdata(intRdata), .intReady(intReady), .extRdata(extRdata),
    .extRvalid(extRvalid), .extRready(extRready), .extWdata(extWdata),
    .extWvalid(extWvalid), .extWready(extWready)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] memWord(input logic [22:0] w);
    logic [31:0] z;
    z = {9'd0, w};
    return {~z, z + 32'h1111_0000, {w, 9'h0} ^ 32'hDEAD_BEEF, z ^ 32'h0BAD_F00D};
  endfunction

  function automatic logic [31:0] wBeat(input int b, input int k);
    return {8'(b), 8'(k), 16'(k * 40503 + b)};
  endfunction

  task automatic runBurst(input bit wr, input int words, input logic [26:0] addr,
                          input bit stall, input bit poke);
    int fetched = 0, rb = 0, sent = 0, commits = 0, cyc = 0, r8Word = -1;
    bit gap = 0, seenValid = 0;
    logic [22:0] baseW;
    logic [127:0] mw, expW;
    baseW = addr[26:4];
    burstId++;
    @(negedge clk);
    extStart = 1'b1; extWrite = wr; extAddr = addr; extLen = 4'(words - 1);
    @(negedge clk);
    forever begin
      cyc++;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      extStart  = poke && (cyc == 3);
      if (poke && cyc == 3) begin
        extWrite = !wr; extLen = 4'd15; extAddr = 27'h0123450;
      end
      intReady  = stall ? (lfsr[0] | lfsr[3]) : 1'b1;
      extRready = stall ? (lfsr[1] | lfsr[5]) : 1'b1;
      extWvalid = (sent < 4 * words) && (stall ? (lfsr[2] | lfsr[6]) : 1'b1);
      extWdata  = wBeat(burstId, sent);
      #1;
      if (cyc == 1) chk(xferActive === 1'b1, "R2 active after start", 128'(xferActive), 128'(1));
      if (!xferActive) break;
      // R8: next fetch done or in flight when a word starts draining
      if (!wr && extRvalid && (rb % 4 == 0) && (rb / 4 != r8Word)) begin
        r8Word = rb / 4;
        if (r8Word + 1 < words)
          chk(intReq || (fetched > r8Word + 1), "R8 prefetch", 128'(fetched), 128'(r8Word + 2));
      end
      if (intReq && intReady) begin
        int idx;
        idx = wr ? commits : fetched;
        chk(intAddr === {baseW + 23'(idx), addr[3:0]}, "R3 address", 128'(intAddr),
            128'({baseW + 23'(idx), addr[3:0]}));
        chk(intWe === wr, "R3 write flag", 128'(intWe), 128'(wr));
        if (!wr) begin
          intRdata = memWord(intAddr[26:4]);
          fetched++;
        end else begin
          expW = {wBeat(burstId, 4*commits+3), wBeat(burstId, 4*commits+2),
                  wBeat(burstId, 4*commits+1), wBeat(burstId, 4*commits)};
          chk(intWdata === expW, "R5 packed word", intWdata, expW);
          chk(sent >= 4 * (commits + 1), "R5 commit after four beats", 128'(sent),
              128'(4 * (commits + 1)));
          commits++;
        end
      end
      if (extRvalid) seenValid = 1;
      if (!stall && !wr && seenValid && !extRvalid) gap = 1;
      if (!stall && wr && sent < 4 * words && !extWready) gap = 1;
      if (extRvalid && extRready) begin
        mw = memWord(baseW + 23'(rb / 4));
        chk(extRdata === mw[32*(rb%4) +: 32], stall ? "R6 stalled beat" : "R4 beat order",
            128'(extRdata), 128'(mw[32*(rb%4) +: 32]));
        rb++;
      end
      if (extWvalid && extWready) sent++;
      @(negedge clk);
      if (cyc > 3000) begin
        chk(1'b0, "R10 timeout", 128'(cyc), 128'(0));
        break;
      end
    end
    extStart = 1'b0;
    if (!wr) chk(rb == 4 * words && fetched == words, "R10 read totals", 128'(rb), 128'(4 * words));
    else chk(commits == words && sent == 4 * words, "R10 write totals", 128'(commits), 128'(words));
    chk(!intReq && !extRvalid && !extWready, "R10 quiet at end",
        128'({intReq, extRvalid, extWready}), 128'(0));
    if (!stall) chk(!gap, "R7 gap-free burst", 128'(gap), 128'(0));
    if (poke) chk(!xferActive, "R9 stray start ignored", 128'(xferActive), 128'(0));
  endtask

  initial begin
    #(4 * 190000);
    chk(1'b0, "R10 watchdog", 128'(1), 128'(0));
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rstN = 1'b0; extStart = 1'b0; extWrite = 1'b0; extAddr = '0; extLen = '0;
    intRdata = '0; intReady = 1'b0; extRready = 1'b0; extWdata = '0; extWvalid = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(xferActive === 1'b0, "R1 reset active", 128'(xferActive), 128'(0));
    chk(intReq === 1'b0, "R1 reset intReq", 128'(intReq), 128'(0));
    chk(extRvalid === 1'b0, "R1 reset extRvalid", 128'(extRvalid), 128'(0));
    chk(extWready === 1'b0, "R1 reset extWready", 128'(extWready), 128'(0));
    for (int w = 1; w <= 16; w++) begin
      logic [26:0] a;
      a = {23'(w * 4951), 4'(w)};
      runBurst(1'b0, w, a, 1'b0, 1'b0);
      runBurst(1'b1, w, a, 1'b0, 1'b0);
      runBurst(1'b0, w, a ^ 27'h5550000, 1'b1, 1'b0);
      runBurst(1'b1, w, a ^ 27'h5550000, 1'b1, 1'b0);
    end
    // address wrap at the top of the space
    runBurst(1'b0, 16, 27'h7FFFFFA, 1'b1, 1'b0);
    runBurst(1'b1, 16, 27'h7FFFFFA, 1'b0, 1'b0);
    // start pulses during an active burst
    runBurst(1'b0, 8, 27'h0040000, 1'b1, 1'b1);
    runBurst(1'b1, 8, 27'h0080000, 1'b1, 1'b1);
    runBurst(1'b0, 4, 27'h00C0000, 1'b0, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule